// File: doc/BRIEF.md
# Vector Any-Element-Equal Search Unit

This unit takes two 128-bit vector operands and treats each as a row of equal-sized elements of 8, 16 or 32 bits. Every element of operand A is compared against every element of operand B, whatever its position, and is marked a hit when any of them is equal. Three option flags shape the answer: the hit sense can be complemented, the result can be a per-element mask or a byte index, and A can also be scanned for an all-zero element. The zero scan acts as a string terminator in the index result and in the condition code.

A 2-bit condition code ranks the first hit against the first zero element. Results are registered, so an operation presented with `valid_i` appears on the outputs one clock later together with `valid_o`. Between operations the output register holds its value.

Top module: `vec_anyeq_search`

## Requirements
- R1: `es_i` picks the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 behaves exactly as 2. Elements and bytes are numbered from the most significant end, so byte offset 0 is bits [127:120].
- R2: An element of A is a hit when it equals any element of B at any position, including positions in the other 64-bit half.
- R3: With `inv_i` set, the hit status of every element is complemented before the index, the mask and the condition code are formed.
- R4: With `rt_i` clear (index mode), `res_o[127:64]` holds the smaller of the first-hit byte offset and the first-zero byte offset, where 16 stands for not found.
- R5: In index mode `res_o[63:0]` is zero.
- R6: With `rt_i` set (mask mode), each element of `res_o` is all ones where the element of A is a hit (after inversion) and all zeros elsewhere, whatever `zs_i` is.
- R7: With `zs_i` clear, the first-zero offset is treated as 16 (not found); with it set, the first all-zero element of A gives the offset.
- R8: `cc_o` is 3 with neither a hit nor a zero, 1 with a hit and no zero, 2 when the first hit lies strictly before the first zero, and 0 otherwise (a zero at or before the first hit). It is produced in both result modes.
- R9: `valid_o` equals `valid_i` one cycle earlier; `res_o` and `cc_o` are updated only on a cycle with `valid_i` high and otherwise hold.
- R10: After reset `valid_o`, `res_o` and `cc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | 128 | Searched operand A |
| b_i | input | 128 | Set of candidate elements B |
| es_i | input | 2 | Element size select |
| inv_i | input | 1 | Complement hit sense |
| rt_i | input | 1 | 1: mask result, 0: index result |
| zs_i | input | 1 | Also search A for a zero element |
| valid_i | input | 1 | Operation present this cycle |
| res_o | output | 128 | Result vector |
| cc_o | output | 2 | Condition code |
| valid_o | output | 1 | Result valid |

## Verification
The hardest situation to reach is a tie or near-tie between the first hit and the first zero, together with matches that exist only across positions or halves, since uniform random operands almost never contain equal elements or zero elements. The stimulus therefore copies randomly chosen elements of A into random positions of B and clears random elements of A, at a density that varies per vector, and sweeps every element size and flag combination. Directed cases add a zero element that is itself a hit (code 0 at equal offsets), byte patterns that match at 8 bits but not at 16, and the hold behaviour with `valid_i` low.

// File: rtl/vsearch_pkg.sv
package vsearch_pkg;
  localparam int VEC_BITS = 128;
  localparam int VEC_BYTES = VEC_BITS / 8;
  localparam int IDX_W = $clog2(VEC_BYTES + 1);
  localparam int NUM_SIZES = 3;

  typedef struct packed {
    logic sel8;
    logic sel16;
    logic sel32;
    logic invert;
    logic maskMode;
    logic zeroSearch;
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/vsearch_ctrl.sv
module vsearch_ctrl
  import vsearch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   es_i,
  input  logic         inv_i,
  input  logic         rt_i,
  input  logic         zs_i,
  input  logic         valid_i,
  output ctrlStrobes_t strb,
  output logic         valid_o
);
  always_comb begin
    strb = '0;
    strb.sel8       = (es_i == 2'd0);
    strb.sel16      = (es_i == 2'd1);
    strb.sel32      = es_i[1];
    strb.invert     = inv_i;
    strb.maskMode   = rt_i;
    strb.zeroSearch = zs_i;
    strb.load       = valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
  end

  assert_size_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.sel8, strb.sel16, strb.sel32}) == 1);

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
endmodule

// File: rtl/vsearch_dp.sv
module vsearch_dp
  import vsearch_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VEC_BITS-1:0] aVec,
  input  logic [VEC_BITS-1:0] bVec,
  input  ctrlStrobes_t        strb,
  output logic [VEC_BITS-1:0] resQ,
  output logic [1:0]          ccQ
);
  localparam int HALF = VEC_BITS / 2;

  logic [VEC_BYTES-1:0] hitBytes  [NUM_SIZES];
  logic [VEC_BYTES-1:0] zeroBytes [NUM_SIZES];

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    localparam int W  = 8 << gs;
    localparam int EB = W / 8;
    localparam int NE = VEC_BITS / W;
    logic [VEC_BYTES-1:0] hitL, zeroL;

    always_comb begin
      hitL = '0;
      zeroL = '0;
      for (int k = 0; k < NE; k++) begin
        logic [W-1:0] aEl;
        logic anyEq;
        aEl = aVec[VEC_BITS-1-k*W -: W];
        anyEq = 1'b0;
        for (int j = 0; j < NE; j++)
          anyEq = anyEq | (aEl == bVec[VEC_BITS-1-j*W -: W]);
        for (int m = 0; m < EB; m++) begin
          hitL[k*EB+m]  = anyEq;
          zeroL[k*EB+m] = (aEl == '0);
        end
      end
    end

    assign hitBytes[gs]  = hitL;
    assign zeroBytes[gs] = zeroL;
  end

  function automatic logic [IDX_W-1:0] firstSet(input logic [VEC_BYTES-1:0] f);
    logic [IDX_W-1:0] idx;
    idx = IDX_W'(VEC_BYTES);
    for (int i = VEC_BYTES - 1; i >= 0; i--)
      if (f[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  logic [VEC_BYTES-1:0] hitSel, zeroSel, hitEff, zeroEff;
  logic [IDX_W-1:0]     hitIdx, zeroIdx, minIdx;
  logic [1:0]           ccNext;
  logic [VEC_BITS-1:0]  maskRes, idxRes, resNext;

  always_comb begin
    if (strb.sel8)       begin hitSel = hitBytes[0]; zeroSel = zeroBytes[0]; end
    else if (strb.sel16) begin hitSel = hitBytes[1]; zeroSel = zeroBytes[1]; end
    else                 begin hitSel = hitBytes[2]; zeroSel = zeroBytes[2]; end
    hitEff  = strb.invert ? ~hitSel : hitSel;
    zeroEff = strb.zeroSearch ? zeroSel : '0;
    hitIdx  = firstSet(hitEff);
    zeroIdx = firstSet(zeroEff);
    minIdx  = (hitIdx < zeroIdx) ? hitIdx : zeroIdx;

    if (hitIdx == IDX_W'(VEC_BYTES) && zeroIdx == IDX_W'(VEC_BYTES)) ccNext = 2'd3;
    else if (zeroIdx == IDX_W'(VEC_BYTES))                           ccNext = 2'd1;
    else if (hitIdx < zeroIdx)                                       ccNext = 2'd2;
    else                                                             ccNext = 2'd0;

    for (int m = 0; m < VEC_BYTES; m++)
      maskRes[VEC_BITS-1-8*m -: 8] = {8{hitEff[m]}};
    idxRes  = {{(HALF-IDX_W){1'b0}}, minIdx, {HALF{1'b0}}};
    resNext = strb.maskMode ? maskRes : idxRes;
  end

  logic maskQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resQ  <= '0;
      ccQ   <= '0;
      maskQ <= 1'b0;
    end else if (strb.load) begin
      resQ  <= resNext;
      ccQ   <= ccNext;
      maskQ <= strb.maskMode;
    end
  end

  assert_index_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !maskQ |-> resQ[HALF-1:0] == '0);

  assert_nomatch_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!maskQ && ccQ == 2'd3) |-> resQ[VEC_BITS-1:HALF] == HALF'(VEC_BYTES));

  assert_found_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!maskQ && ccQ != 2'd3) |-> resQ[VEC_BITS-1:HALF] < HALF'(VEC_BYTES));

  assert_mask_has_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ && ccQ == 2'd1) |-> resQ != '0);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(resQ) && $stable(ccQ));
endmodule

// File: rtl/vec_anyeq_search.sv
module vec_anyeq_search
  import vsearch_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [127:0]   a_i,
  input  logic [127:0]   b_i,
  input  logic [1:0]     es_i,
  input  logic           inv_i,
  input  logic           rt_i,
  input  logic           zs_i,
  input  logic           valid_i,
  output logic [127:0]   res_o,
  output logic [1:0]     cc_o,
  output logic           valid_o
);
  ctrlStrobes_t strb;

  vsearch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .es_i(es_i), .inv_i(inv_i), .rt_i(rt_i),
    .zs_i(zs_i), .valid_i(valid_i), .strb(strb), .valid_o(valid_o)
  );

  vsearch_dp u_dp (
    .clk(clk), .rst_n(rst_n), .aVec(a_i), .bVec(b_i), .strb(strb),
    .resQ(res_o), .ccQ(cc_o)
  );
endmodule

// File: tb/vec_anyeq_search_tb.sv
module vec_anyeq_search_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic [1:0] es_i = '0;
  logic inv_i = 0, rt_i = 0, zs_i = 0, valid_i = 0;
  logic [127:0] res_o;
  logic [1:0] cc_o;
  logic valid_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vec_anyeq_search u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .es_i(es_i),
    .inv_i(inv_i), .rt_i(rt_i), .zs_i(zs_i), .valid_i(valid_i),
    .res_o(res_o), .cc_o(cc_o), .valid_o(valid_o)
  );

  function automatic int elemW(input logic [1:0] es);
    return (es == 2'd3) ? 32 : (8 << es);
  endfunction

  function automatic logic [31:0] getEl(input logic [127:0] v, input int w, input int k);
    logic [127:0] s;
    s = v >> (128 - (k + 1) * w);
    return s[31:0] & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1));
  endfunction

  function automatic logic [127:0] setEl(input logic [127:0] v, input int w, input int k,
                                         input logic [31:0] x);
    logic [127:0] m, xv;
    int sh;
    sh = 128 - (k + 1) * w;
    m  = ((w == 32) ? 128'hFFFF_FFFF : ((128'd1 << w) - 1)) << sh;
    xv = (128'(x) << sh) & m;
    return (v & ~m) | xv;
  endfunction

  task automatic refModel(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
                          input logic inv, input logic rt, input logic zs,
                          output logic [127:0] r, output logic [1:0] c);
    int w, ne, hitIdx, zeroIdx, mn;
    logic h;
    w = elemW(es);
    ne = 128 / w;
    hitIdx = 16;
    zeroIdx = 16;
    r = '0;
    for (int k = 0; k < ne; k++) begin
      h = 1'b0;
      for (int j = 0; j < ne; j++)
        if (getEl(a, w, k) == getEl(b, w, j)) h = 1'b1;
      if (inv) h = ~h;
      if (h && hitIdx == 16) hitIdx = k * w / 8;
      if (zs && getEl(a, w, k) == 0 && zeroIdx == 16) zeroIdx = k * w / 8;
      if (h) r = setEl(r, w, k, 32'hFFFF_FFFF);
    end
    mn = (hitIdx < zeroIdx) ? hitIdx : zeroIdx;
    if (!rt) r = {64'(mn), 64'd0};
    if (hitIdx == 16 && zeroIdx == 16) c = 2'd3;
    else if (zeroIdx == 16)            c = 2'd1;
    else if (hitIdx < zeroIdx)         c = 2'd2;
    else                               c = 2'd0;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] a, input logic [127:0] b, input logic [1:0] es,
                       input logic inv, input logic rt, input logic zs);
    @(negedge clk);
    a_i = a; b_i = b; es_i = es; inv_i = inv; rt_i = rt; zs_i = zs; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic runCheck(input string resTag, input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] es, input logic inv, input logic rt, input logic zs);
    logic [127:0] er;
    logic [1:0] ec;
    refModel(a, b, es, inv, rt, zs, er, ec);
    runOp(a, b, es, inv, rt, zs);
    chk(resTag, res_o, er);
    chk("R8", 128'(cc_o), 128'(ec));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] a, b, r0;
    logic [1:0] c0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {res_o[127:2], cc_o, valid_o}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: cross-position byte hit at offset 5, no zero search
    a = {16{8'h11}}; a = setEl(a, 8, 5, 32'h41);
    b = {16{8'h22}}; b = setEl(b, 8, 12, 32'h41);
    runOp(a, b, 2'd0, 0, 0, 0);
    chk("R2", res_o, {64'd5, 64'd0});
    chk("R8", 128'(cc_o), 128'd1);
    chk("R9", 128'(valid_o), 128'd1);
    // R3: inverted sense, first non-hit is offset 0
    runOp(a, b, 2'd0, 1, 0, 0);
    chk("R3", res_o, {64'd0, 64'd0});
    // R7: zero at offset 2 ignored without zero search
    a = setEl(a, 8, 2, 32'h0);
    runOp(a, b, 2'd0, 0, 0, 0);
    chk("R7", res_o, {64'd5, 64'd0});
    runOp(a, b, 2'd0, 0, 0, 1);
    chk("R7", res_o, {64'd2, 64'd0});
    chk("R8", 128'(cc_o), 128'd0);
    // R8: hit before zero gives 2
    a = setEl(a, 8, 2, 32'h11); a = setEl(a, 8, 9, 32'h0);
    runOp(a, b, 2'd0, 0, 0, 1);
    chk("R8", 128'(cc_o), 128'd2);
    chk("R4", res_o, {64'd5, 64'd0});
    // R8: zero element that is also a hit, equal offsets gives 0
    b = setEl(b, 8, 0, 32'h0);
    a = {16{8'h33}}; a = setEl(a, 8, 7, 32'h0);
    runOp(a, b, 2'd0, 0, 0, 1);
    chk("R8", 128'(cc_o), 128'd0);
    chk("R4", res_o, {64'd7, 64'd0});
    // R1: bytes match but halfwords do not
    a = {8{16'h5555}}; a = setEl(a, 16, 3, 32'h1234);
    b = {8{16'h6666}}; b = setEl(b, 16, 6, 32'h3412);
    runOp(a, b, 2'd1, 0, 0, 0);
    chk("R1", res_o, {64'd16, 64'd0});
    chk("R8", 128'(cc_o), 128'd3);
    runOp(a, b, 2'd0, 0, 0, 0);
    chk("R1", res_o, {64'd6, 64'd0});
    // R1: size code 3 behaves as 32-bit; R2 across halves
    a = {32'h1, 32'h2, 32'h3, 32'h0};
    b = {32'h9, 32'h3, 32'h8, 32'h7};
    runOp(a, b, 2'd3, 0, 1, 1);
    chk("R1", res_o, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0});
    // R6: mask unaffected by zero search
    runOp(a, b, 2'd2, 0, 1, 0);
    chk("R6", res_o, {32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0});
    chk("R8", 128'(cc_o), 128'd1);
    // R9: hold while valid_i low, with different inputs applied
    r0 = res_o; c0 = cc_o;
    @(negedge clk);
    a_i = '0; b_i = '1; rt_i = 0; zs_i = 1; es_i = 2'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", res_o, r0);
    chk("R9", 128'(cc_o), 128'(c0));
    chk("R9", 128'(valid_o), 128'd0);

    // Random sweep over sizes and flags with seeded repeats and zeros
    void'($urandom(32'h5EA4C11));
    for (int i = 0; i < 800; i++) begin
      logic [1:0] es;
      logic inv, rt, zs;
      int w, ne, nRep, nZero;
      es = 2'(i % 4);
      {inv, rt, zs} = 3'((i / 4) % 8);
      w = elemW(es);
      ne = 128 / w;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      nRep = $urandom_range(0, 3);
      nZero = $urandom_range(0, 2);
      for (int n = 0; n < nRep; n++)
        b = setEl(b, w, $urandom_range(0, ne - 1), getEl(a, w, $urandom_range(0, ne - 1)));
      for (int n = 0; n < nZero; n++)
        a = setEl(a, w, $urandom_range(0, ne - 1), 32'h0);
      if (rt) runCheck("R6", a, b, es, inv, rt, zs);
      else    runCheck("R4", a, b, es, inv, rt, zs);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule